// File: doc/BRIEF.md
# Conflict-Only Instruction Cache

This block sits between an instruction sequencer and a single-ported program memory that also serves data reads. Most fetches go straight to memory and never touch the cache. A fetch is looked up only when, in the same cycle, a data access also needs program memory. On a hit the stored instruction is returned at once, and memory is left free for the data access. On a miss the data access keeps memory for that cycle. The block stalls the sequencer for one cycle, fetches the instruction in the next cycle, and stores it so that the next collision at that address hits.

The store holds 32 words of 48 bits, arranged as 16 sets of 2 ways. The set comes from the low four bits of the 24-bit fetch address and the tag from the upper twenty. Each set keeps one recency bit that chooses which way a fill replaces. A disable input turns off both lookups and fills, so every collision then costs one cycle. A flush input marks every entry invalid. Program memory is modelled as a read port that returns its word in the same cycle as the address.

Top module: `conflict_icache`

## Requirements
- R1: After reset every entry is invalid: with no fetch requested, `stall`, `instr_valid` and `pm_rd` are low, and the first colliding fetch to any address is a miss.
- R2: A fetch with `pm_data_req` low drives `pm_rd` high and `pm_addr` equal to `fetch_addr`, and returns `pm_rdata` on `instr_out` in the same cycle with `instr_valid` high and `stall` low. Such a fetch never stores anything. With `fetch_valid` low, and no retry pending, `pm_rd` and `instr_valid` stay low.
- R3: A colliding fetch that misses raises `stall` in that cycle, with `pm_rd` and `instr_valid` low.
- R4: In the cycle after a miss the block ignores its fetch inputs. It drives `pm_rd` with `pm_addr` equal to the missed address, returns `pm_rdata` with `instr_valid` high and `stall` low, and writes that word into the store.
- R5: A colliding fetch that hits returns the stored word on `instr_out` in the same cycle, with `instr_valid` high and both `pm_rd` and `stall` low.
- R6: The set index is `fetch_addr[3:0]` and the tag is `fetch_addr[23:4]`. Two addresses with the same set index and different tags can be held at the same time.
- R7: A fill uses way 0 if it is invalid, otherwise way 1 if that is invalid. Otherwise it uses the way named by the set's recency bit. Every hit or fill on way w sets that bit to the other way. The recency bits reset to way 0.
- R8: While `cache_dis` is high, a colliding fetch is always handled as a miss and does not update the recency bit. A miss taken while disabled stores nothing, even if `cache_dis` falls in the retry cycle.
- R9: `flush` high in a cycle invalidates every entry from the next cycle on. A flush in a retry cycle also cancels that cycle's fill.
- R10: `stall` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Sequencer requests an instruction |
| fetch_addr | input | 24 | Instruction address |
| pm_data_req | input | 1 | A data access to program memory occurs this cycle |
| cache_dis | input | 1 | Disables lookups and fills |
| flush | input | 1 | Invalidate all entries |
| pm_rd | output | 1 | Instruction read of program memory this cycle |
| pm_addr | output | 24 | Address of the instruction read |
| pm_rdata | input | 48 | Word returned by program memory in the same cycle |
| instr_valid | output | 1 | `instr_out` carries an instruction |
| instr_out | output | 48 | Delivered instruction |
| stall | output | 1 | Sequencer must hold this cycle |

## Verification
A corrupted tag, valid bit or recency bit appears at the ports the first time the affected set is fetched under a collision. A wrong hit shows `stall` low where one is expected, or the reverse. A stale or misplaced data word shows a wrong `instr_out` in that same cycle. The bench changes the memory contents between passes, so any word that came from the store, and not from memory, can be told apart at once. A faulty retry path shows in the very next cycle as a wrong `pm_addr`, a missing `instr_valid` or a second stall.

// File: rtl/cic_pkg.sv
package cic_pkg;

  typedef enum logic {
    CIC_RUN   = 1'b0,
    CIC_RETRY = 1'b1
  } cic_state_e;

  // fill target: first empty way, else the way the recency bit names
  function automatic logic cic_victim(logic [1:0] vld, logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction

  // after touching a way, the other one becomes the next victim
  function automatic logic cic_lru_next(logic way);
    return ~way;
  endfunction

endpackage

// File: rtl/cic_tag_store.sv
module cic_tag_store #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_way,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             vic_way,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_way
);
  import cic_pkg::*;

  logic [1:0]       vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][2];
  logic             lru_q [SETS];
  logic [1:0]       way_hit;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  assign hit     = |way_hit;
  assign hit_way = way_hit[1];
  assign vic_way = cic_victim(vld_q[fill_idx], lru_q[fill_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= 2'b00;
        lru_q[s] <= 1'b0;
      end
    end else begin
      if (flush) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
      end else if (fill_en) begin
        vld_q[fill_idx][vic_way] <= 1'b1;
      end
      if (acc_en) lru_q[acc_idx] <= cic_lru_next(acc_way);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx][vic_way] <= fill_tag;
  end

endmodule

// File: rtl/cic_data_store.sv
module cic_data_store #(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_way,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_way,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] word_q [SETS][2];

  assign rd_data = word_q[rd_idx][rd_way];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_idx][wr_way] <= wr_data;
  end

endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              conflict,
  input  logic              cache_dis,
  input  logic              lookup_hit,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              run,
  output logic              retry,
  output logic              miss_evt,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              pend_fill_ok
);
  import cic_pkg::*;

  cic_state_e state_q;

  assign run      = (state_q == CIC_RUN);
  assign retry    = (state_q == CIC_RETRY);
  assign miss_evt = run && fetch_valid && conflict && !(lookup_hit && !cache_dis);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= CIC_RUN;
      pend_addr    <= '0;
      pend_fill_ok <= 1'b0;
    end else begin
      state_q <= miss_evt ? CIC_RETRY : CIC_RUN;
      if (miss_evt) begin
        pend_addr    <= fetch_addr;
        pend_fill_ok <= !cache_dis;
      end
    end
  end

endmodule

// File: rtl/conflict_icache.sv
module conflict_icache #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 48,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              pm_data_req,
  input  logic              cache_dis,
  input  logic              flush,
  output logic              pm_rd,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [DATA_W-1:0] pm_rdata,
  output logic              instr_valid,
  output logic [DATA_W-1:0] instr_out,
  output logic              stall
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              run, retry, miss_evt, pend_fill_ok;
  logic [ADDR_W-1:0] pend_addr;
  logic              raw_hit, hit_way, vic_way;
  logic              hit_evt, fill_evt, bypass_evt;
  logic              acc_en, acc_way;
  logic [IDX_W-1:0]  acc_idx;
  logic [DATA_W-1:0] cached_word;

  cic_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .conflict     (pm_data_req),
    .cache_dis    (cache_dis),
    .lookup_hit   (raw_hit),
    .fetch_addr   (fetch_addr),
    .run          (run),
    .retry        (retry),
    .miss_evt     (miss_evt),
    .pend_addr    (pend_addr),
    .pend_fill_ok (pend_fill_ok)
  );

  // named events for the checker
  assign hit_evt    = run && fetch_valid && pm_data_req && !cache_dis && raw_hit;
  assign bypass_evt = run && fetch_valid && !pm_data_req;
  assign fill_evt   = retry && pend_fill_ok && !flush;

  assign acc_en  = hit_evt || fill_evt;
  assign acc_idx = retry ? pend_addr[IDX_W-1:0] : fetch_addr[IDX_W-1:0];
  assign acc_way = retry ? vic_way : hit_way;

  cic_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (fetch_addr[IDX_W-1:0]),
    .lk_tag   (fetch_addr[ADDR_W-1:IDX_W]),
    .hit      (raw_hit),
    .hit_way  (hit_way),
    .flush    (flush),
    .fill_en  (fill_evt),
    .fill_idx (pend_addr[IDX_W-1:0]),
    .fill_tag (pend_addr[ADDR_W-1:IDX_W]),
    .vic_way  (vic_way),
    .acc_en   (acc_en),
    .acc_idx  (acc_idx),
    .acc_way  (acc_way)
  );

  cic_data_store #(.SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
    .clk     (clk),
    .rd_idx  (fetch_addr[IDX_W-1:0]),
    .rd_way  (hit_way),
    .rd_data (cached_word),
    .wr_en   (fill_evt),
    .wr_idx  (pend_addr[IDX_W-1:0]),
    .wr_way  (vic_way),
    .wr_data (pm_rdata)
  );

  assign pm_rd       = retry || bypass_evt;
  assign pm_addr     = retry ? pend_addr : fetch_addr;
  assign instr_valid = hit_evt || pm_rd;
  assign instr_out   = hit_evt ? cached_word : pm_rdata;
  assign stall       = miss_evt;

endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              pm_data_req,
  input logic              cache_dis,
  input logic              flush,
  input logic              pm_rd,
  input logic [ADDR_W-1:0] pm_addr,
  input logic [DATA_W-1:0] pm_rdata,
  input logic              instr_valid,
  input logic [DATA_W-1:0] instr_out,
  input logic              stall,
  input logic              hit_evt,
  input logic              fill_evt,
  input logic              bypass_evt
);
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall); // R10
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stall |-> (!pm_rd && !instr_valid)); // R3
  AST_RETRY_READ: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (pm_rd && instr_valid && pm_addr == $past(fetch_addr))); // R4
  AST_RETRY_WORD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> (instr_out == pm_rdata)); // R4
  AST_FILL_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n) fill_evt |-> ($past(stall) && !$past(cache_dis))); // R8
  AST_HIT_FREE_PM: assert property (@(posedge clk) disable iff (!rst_n) hit_evt |-> (!pm_rd && !stall && instr_valid && pm_data_req)); // R5
  AST_BYPASS_READ: assert property (@(posedge clk) disable iff (!rst_n) bypass_evt |-> (pm_rd && pm_addr == fetch_addr && instr_out == pm_rdata)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!fetch_valid && !$past(stall)) |-> (!pm_rd && !instr_valid)); // R2
  AST_DIS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) cache_dis |-> !hit_evt); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !hit_evt); // R9
endmodule

bind conflict_icache cic_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .pm_data_req (pm_data_req),
  .cache_dis   (cache_dis),
  .flush       (flush),
  .pm_rd       (pm_rd),
  .pm_addr     (pm_addr),
  .pm_rdata    (pm_rdata),
  .instr_valid (instr_valid),
  .instr_out   (instr_out),
  .stall       (stall),
  .hit_evt     (hit_evt),
  .fill_evt    (fill_evt),
  .bypass_evt  (bypass_evt)
);

// File: tb/conflict_icache_tb_top.sv
`timescale 1ns/1ps
module conflict_icache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [23:0] fetch_addr = '0;
  logic        pm_data_req = 1'b0;
  logic        cache_dis = 1'b0;
  logic        flush = 1'b0;
  logic        pm_rd, instr_valid, stall;
  logic [23:0] pm_addr;
  logic [47:0] pm_rdata, instr_out;

  int gen = 1;
  int n_chk = 0;
  int n_bad = 0;

  // reference state built from the requirements
  bit          mv [16][2];
  logic [19:0] mt [16][2];
  logic [47:0] md [16][2];
  bit          ml [16];

  always #2.5 clk = ~clk;

  function automatic logic [47:0] mem_word(logic [23:0] a, int g);
    logic [7:0] gb = g[7:0];
    return {gb, a, ~a[15:0]};
  endfunction

  assign pm_rdata = mem_word(pm_addr, gen);

  conflict_icache dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .pm_data_req(pm_data_req), .cache_dis(cache_dis), .flush(flush),
    .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .instr_valid(instr_valid), .instr_out(instr_out), .stall(stall)
  );

  task automatic chk(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [3:0] s, logic [19:0] t);
    for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) return w;
    return -1;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < 16; s++) begin mv[s][0] = 0; mv[s][1] = 0; end
  endtask

  // one fetch; fl_retry raises flush in the retry cycle of a miss
  task automatic op_fetch(logic [23:0] a, bit conf, bit dis, bit fl_retry, string req);
    logic [3:0]  s = a[3:0];
    logic [19:0] t = a[23:4];
    int hw;
    bit exp_hit;
    int v;
    @(negedge clk);
    fetch_valid = 1; fetch_addr = a; pm_data_req = conf; cache_dis = dis; flush = 0;
    #1;
    if (!conf) begin
      chk(pm_rd && pm_addr == a && instr_valid && !stall, "R2", "bypass control",
          {23'd0, pm_rd, pm_addr}, {24'd1, a});
      chk(instr_out == mem_word(a, gen), "R2", "bypass word", instr_out, mem_word(a, gen));
      return;
    end
    hw = m_find(s, t);
    exp_hit = !dis && hw >= 0;
    chk(stall == !exp_hit, req, "hit/miss by stall", {47'd0, stall}, {47'd0, !exp_hit});
    if (exp_hit) begin
      chk(instr_valid && !pm_rd && !stall, "R5", "hit control",
          {46'd0, instr_valid, pm_rd}, 48'd2);
      chk(instr_out == md[s][hw], "R5", "hit word", instr_out, md[s][hw]);
      ml[s] = (hw == 0);
      return;
    end
    chk(!pm_rd && !instr_valid, "R3", "miss quiet", {46'd0, pm_rd, instr_valid}, 48'd0);
    @(negedge clk);
    flush = fl_retry;
    cache_dis = 0;
    fetch_addr = a ^ 24'h5A5A50;  // ignored in the retry cycle
    #1;
    chk(pm_rd && pm_addr == a && instr_valid, "R4", "retry read",
        {23'd0, pm_rd, pm_addr}, {24'd1, a});
    chk(instr_out == mem_word(a, gen), "R4", "retry word", instr_out, mem_word(a, gen));
    chk(!stall, "R10", "single stall", {47'd0, stall}, 48'd0);
    if (fl_retry) m_clear();
    else if (!dis) begin
      v = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(ml[s]));
      mv[s][v] = 1; mt[s][v] = t; md[s][v] = mem_word(a, gen);
      ml[s] = (v == 0);
    end
    @(negedge clk);
    flush = 0;
    fetch_valid = 0;
    pm_data_req = 0;
  endtask

  task automatic op_flush();
    @(negedge clk);
    fetch_valid = 0; pm_data_req = 0; cache_dis = 0; flush = 1;
    #1;
    chk(!pm_rd && !instr_valid && !stall, "R2", "idle quiet",
        {45'd0, pm_rd, instr_valid, stall}, 48'd0);
    m_clear();
    @(negedge clk);
    flush = 0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] r;
    m_clear();
    for (int s = 0; s < 16; s++) ml[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!stall && !instr_valid && !pm_rd, "R1", "reset outputs",
        {45'd0, stall, instr_valid, pm_rd}, 48'd0);

    // R1: every set starts empty; R2: plain fetches never fill
    for (int s = 0; s < 16; s++) op_fetch({20'h00321, 4'(s)}, 0, 0, 0, "R2");
    for (int s = 0; s < 16; s++) op_fetch({20'h00321, 4'(s)}, 1, 0, 0, "R1");
    gen++;
    for (int s = 0; s < 16; s++) op_fetch({20'h00321, 4'(s)}, 1, 0, 0, "R5");

    // R6: two tags per set coexist, sweep all sets
    op_flush();
    for (int s = 0; s < 16; s++) begin
      op_fetch({20'hA0001, 4'(s)}, 1, 0, 0, "R6");
      op_fetch({20'h0B002, 4'(s)}, 1, 0, 0, "R6");
    end
    gen++;
    for (int s = 0; s < 16; s++) begin
      op_fetch({20'hA0001, 4'(s)}, 1, 0, 0, "R6");
      op_fetch({20'h0B002, 4'(s)}, 1, 0, 0, "R6");
    end

    // R7: victim choice in set 5
    op_flush();
    op_fetch(24'h000015, 1, 0, 0, "R7");
    op_fetch(24'h000025, 1, 0, 0, "R7");
    op_fetch(24'h000015, 1, 0, 0, "R7");
    op_fetch(24'h000035, 1, 0, 0, "R7");
    op_fetch(24'h000015, 1, 0, 0, "R7");
    op_fetch(24'h000025, 1, 0, 0, "R7");
    op_fetch(24'h000035, 1, 0, 0, "R7");

    // R8: disabled collisions miss and do not fill
    op_fetch(24'h000015, 1, 1, 0, "R8");
    op_fetch(24'h000047, 1, 1, 0, "R8");
    op_fetch(24'h000047, 1, 0, 0, "R8");

    // R9: flush clears, flush in retry cancels the fill
    op_flush();
    op_fetch(24'h000047, 1, 0, 0, "R9");
    op_fetch(24'h000058, 1, 0, 1, "R9");
    op_fetch(24'h000058, 1, 0, 0, "R9");
    op_fetch(24'h000047, 1, 0, 0, "R9");

    // mixed sweep
    r = 32'h1234_5678;
    for (int i = 0; i < 5000; i++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      if (r[7:0] < 5) op_flush();
      else begin
        if (r[15:8] < 8) gen++;
        op_fetch({18'h0, r[17:16], r[23:20]}, r[27:24] < 11, r[31:28] == 0,
                 r[11:8] == 3, "R7");
      end
    end
    report();
  end
endmodule